// File: doc/BRIEF.md
# EEPROM Write Interlock Controller

This block stands between the control logic of a calibration-coefficient memory and the charge pump that programs it. The pump may turn on only after a fixed series of unlock codes has been presented on a code bus in the right order, with no more than a bounded gap between neighbouring codes. It then needs a write request that also falls inside the window. A supply glitch that scrambles the control state, or a stray code, cannot reach the programming pulse. Each granted pulse has a fixed length, after which the controller relocks by itself.

A lock input, driven from the memory's own one-time lock bit, latches a sticky flag. From then on every unlock attempt is refused and any pulse in progress is cut off. Only a reset clears the flag, and after reset the memory presents the bit again. A second, independent engine computes a 16-bit LFSR signature over a run of stored words and compares it with a reference value, so that corrupted coefficients are flagged.

Top module: `wlock_ctrl`

## Requirements
- R1: After reset, pump_en, key_ok, perm_locked, sig_done and sig_err are all 0.
- R2: The codes 0xA5, 0x5A, 0xC3 and 0x3C, in that order, each sampled with code_vld high, set key_ok to 1. A wr_req sampled while key_ok is 1 drives pump_en to 1 from the next cycle.
- R3: A wrong code sampled during the key sequence returns the controller to idle, and the next attempt must begin again with 0xA5. Any code sampled while key_ok is 1 also returns it to idle, which clears key_ok.
- R4: Each code after the first, and the wr_req after the last code, must be sampled no more than 256 clock edges after the preceding code. A gap of exactly 256 is accepted. If nothing arrives by edge 256, the controller returns to idle, so a code at edge 257 arrives too late.
- R5: pump_en stays high for exactly 1024 cycles, then falls with key_ok at 0. A new write needs the whole key sequence again.
- R6: pump_en rises only in the cycle after a wr_req sampled while key_ok is 1. A wr_req sampled at any other time has no effect.
- R7: Codes sampled while pump_en is high neither shorten nor lengthen the pulse.
- R8: Once lock_in is sampled high, perm_locked is 1 and pump_en is 0 from the next cycle. Until the next reset, no code sequence sets key_ok and no wr_req raises pump_en.
- R9: A sig_start pulse loads the signature register with 0xFFFF. Each word sampled with word_vld is shifted in MSB first with the polynomial x^16+x^12+x^5+1. After the 8th word, sig_done is 1 and sig_err is 1 exactly when the result differs from sig_ref.
- R10: Words sampled outside a signature run leave sig_done and sig_err unchanged. A new sig_start clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Code strobe |
| code | input | 8 | Unlock code |
| wr_req | input | 1 | Write request |
| lock_in | input | 1 | One-time lock bit from the memory |
| sig_start | input | 1 | Starts a signature run |
| word_vld | input | 1 | Word strobe for the signature |
| word | input | 16 | Stored coefficient word |
| sig_ref | input | 16 | Expected signature |
| pump_en | output | 1 | Charge-pump enable |
| key_ok | output | 1 | Key accepted, waiting for write request |
| perm_locked | output | 1 | Permanent lock latched |
| sig_done | output | 1 | Signature run complete |
| sig_err | output | 1 | Signature mismatch |

## Verification
A corrupted sequencer state shows up as key_ok rising early or late. With an off-by-one in the gap timer, it shows as a sequence that is accepted or refused on the wrong side of the 256-edge boundary, visible on the next code. A slip in the pulse counter is visible only at the end of a pulse, up to 1024 cycles later, as a high count that differs from 1024. A fault in the lock latch appears within one cycle as perm_locked, or as pump_en surviving the lock. A wrong signature state stays hidden until the 8th word, when sig_err takes the wrong value.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    localparam int              SIG_W    = 16;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
    localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

    // Sparse encoding: the pump state sits two bit flips away from every other state
    typedef enum logic [2:0] {
        WL_IDLE    = 3'b000,
        WL_COLLECT = 3'b011,
        WL_ARMED   = 3'b110,
        WL_PROG    = 3'b101
    } wl_state_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic err;
    } wl_sig_stat_t;

    // Shift one word into the signature, most significant bit first
    function automatic logic [SIG_W-1:0] lfsr_word(input logic [SIG_W-1:0] c,
                                                   input logic [SIG_W-1:0] w);
        logic [SIG_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            fb = r[SIG_W-1] ^ w[i];
            r  = {r[SIG_W-2:0], 1'b0};
            if (fb) r = r ^ SIG_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/wlock_seq.sv
module wlock_seq
    import wlock_pkg::*;
#(
    parameter int                     CODE_W  = 8,
    parameter int                     NKEYS   = 4,
    parameter logic [NKEYS*CODE_W-1:0] KEY_SEQ = 32'hA55AC33C,
    parameter int                     WIN     = 256,
    parameter int                     PULSE   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    input  logic              wr_req,
    input  logic              lock_i,
    output logic              pump_en,
    output logic              armed
);
    localparam int TW = (WIN > 1)   ? $clog2(WIN)   : 1;
    localparam int PW = (PULSE > 1) ? $clog2(PULSE) : 1;
    localparam int SW = (NKEYS > 1) ? $clog2(NKEYS) : 1;

    wl_state_t     state, state_n;
    logic [TW-1:0] tmr, tmr_n;
    logic [PW-1:0] pcnt, pcnt_n;
    logic [SW-1:0] stage, stage_n;
    logic [CODE_W-1:0] expect_code;

    function automatic logic [CODE_W-1:0] key_at(input logic [SW-1:0] idx);
        return KEY_SEQ[(NKEYS - 1 - int'(idx)) * CODE_W +: CODE_W];
    endfunction

    assign expect_code = key_at(stage);

    always_comb begin
        state_n = state;
        stage_n = stage;
        tmr_n   = '0;
        pcnt_n  = '0;
        case (state)
            WL_IDLE: begin
                if (code_vld && code == key_at('0)) begin
                    state_n = (NKEYS == 1) ? WL_ARMED : WL_COLLECT;
                    stage_n = SW'(1 % NKEYS);
                end
            end
            WL_COLLECT: begin
                tmr_n = tmr + 1'b1;
                if (code_vld) begin
                    tmr_n = '0;
                    if (code != expect_code) begin
                        state_n = WL_IDLE;
                        stage_n = '0;
                    end else if (stage == SW'(NKEYS - 1)) begin
                        state_n = WL_ARMED;
                        stage_n = '0;
                    end else begin
                        stage_n = stage + 1'b1;
                    end
                end else if (tmr == TW'(WIN - 1)) begin
                    state_n = WL_IDLE;
                    stage_n = '0;
                end
            end
            WL_ARMED: begin
                tmr_n = tmr + 1'b1;
                if (code_vld) begin
                    state_n = WL_IDLE;
                end else if (wr_req) begin
                    state_n = WL_PROG;
                end else if (tmr == TW'(WIN - 1)) begin
                    state_n = WL_IDLE;
                end
            end
            WL_PROG: begin
                pcnt_n = pcnt + 1'b1;
                if (pcnt == PW'(PULSE - 1)) state_n = WL_IDLE;
            end
            default: begin
                state_n = WL_IDLE;
                stage_n = '0;
            end
        endcase
        if (lock_i) begin
            state_n = WL_IDLE;
            stage_n = '0;
        end
        if (state_n == WL_IDLE) begin
            tmr_n  = '0;
            pcnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WL_IDLE;
            stage <= '0;
            tmr   <= '0;
            pcnt  <= '0;
        end else begin
            state <= state_n;
            stage <= stage_n;
            tmr   <= tmr_n;
            pcnt  <= pcnt_n;
        end
    end

    assign pump_en = (state == WL_PROG);
    assign armed   = (state == WL_ARMED);

    AST_PUMP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(state == WL_PROG) |-> $past(state == WL_ARMED && wr_req && !code_vld && !lock_i)); // R6
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        (state == WL_COLLECT && code_vld && code != expect_code) |=> state == WL_IDLE); // R3
    AST_GAP_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        (state == WL_COLLECT && tmr == TW'(WIN - 1) && !code_vld) |=> state == WL_IDLE); // R4
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(state == WL_PROG) |-> ($past(pcnt) == PW'(PULSE - 1) || $past(lock_i))); // R5
    AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        lock_i |=> state == WL_IDLE); // R8

endmodule

// File: rtl/wlock_sig.sv
module wlock_sig
    import wlock_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             word_vld,
    input  logic [SIG_W-1:0] word,
    input  logic [SIG_W-1:0] ref_val,
    output logic             done,
    output logic             err
);
    localparam int CW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    wl_sig_stat_t     st;
    logic [SIG_W-1:0] acc, acc_nx;
    logic [CW-1:0]    cnt;

    assign acc_nx = lfsr_word(acc, word);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            acc <= SIG_SEED;
            cnt <= '0;
        end else if (start) begin
            st  <= '{busy: 1'b1, done: 1'b0, err: 1'b0};
            acc <= SIG_SEED;
            cnt <= '0;
        end else if (word_vld && st.busy) begin
            acc <= acc_nx;
            if (cnt == CW'(NWORDS - 1)) begin
                st.busy <= 1'b0;
                st.done <= 1'b1;
                st.err  <= (acc_nx != ref_val);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = st.done;
    assign err  = st.err;

    AST_SIG_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(st.done) |-> $past(word_vld && st.busy)); // R9
    AST_SIG_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        st.err |-> st.done); // R9
    AST_SIG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!st.busy && !start) |=> ($stable(acc) && $stable(st.err))); // R10

endmodule

// File: rtl/wlock_ctrl.sv
module wlock_ctrl
    import wlock_pkg::*;
#(
    parameter int                     CODE_W  = 8,
    parameter int                     NKEYS   = 4,
    parameter logic [NKEYS*CODE_W-1:0] KEY_SEQ = 32'hA55AC33C,
    parameter int                     WIN     = 256,
    parameter int                     PULSE   = 1024,
    parameter int                     NWORDS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    input  logic              wr_req,
    input  logic              lock_in,
    input  logic              sig_start,
    input  logic              word_vld,
    input  logic [SIG_W-1:0]  word,
    input  logic [SIG_W-1:0]  sig_ref,
    output logic              pump_en,
    output logic              key_ok,
    output logic              perm_locked,
    output logic              sig_done,
    output logic              sig_err
);
    logic perm_q;
    logic lock_any;

    always_ff @(posedge clk) begin
        if (rst) perm_q <= 1'b0;
        else     perm_q <= perm_q | lock_in;
    end

    assign lock_any    = perm_q | lock_in;
    assign perm_locked = perm_q;

    wlock_seq #(
        .CODE_W (CODE_W),
        .NKEYS  (NKEYS),
        .KEY_SEQ(KEY_SEQ),
        .WIN    (WIN),
        .PULSE  (PULSE)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .code_vld(code_vld),
        .code    (code),
        .wr_req  (wr_req),
        .lock_i  (lock_any),
        .pump_en (pump_en),
        .armed   (key_ok)
    );

    wlock_sig #(
        .NWORDS(NWORDS)
    ) u_sig (
        .clk     (clk),
        .rst     (rst),
        .start   (sig_start),
        .word_vld(word_vld),
        .word    (word),
        .ref_val (sig_ref),
        .done    (sig_done),
        .err     (sig_err)
    );

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        perm_q |=> perm_q); // R8
    AST_LOCK_NO_PUMP: assert property (@(posedge clk) disable iff (rst)
        perm_q |-> (!pump_en && !key_ok)); // R8

endmodule

// File: tb/wlock_ctrl_tb.sv
module wlock_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_vld = 1'b0;
    logic [7:0]  code = '0;
    logic        wr_req = 1'b0;
    logic        lock_in = 1'b0;
    logic        sig_start = 1'b0;
    logic        word_vld = 1'b0;
    logic [15:0] word = '0;
    logic [15:0] sig_ref = '0;
    logic        pump_en, key_ok, perm_locked, sig_done, sig_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wlock_ctrl u_dut (
        .clk(clk), .rst(rst), .code_vld(code_vld), .code(code), .wr_req(wr_req),
        .lock_in(lock_in), .sig_start(sig_start), .word_vld(word_vld), .word(word),
        .sig_ref(sig_ref), .pump_en(pump_en), .key_ok(key_ok), .perm_locked(perm_locked),
        .sig_done(sig_done), .sig_err(sig_err)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_code(input logic [7:0] c);
        code_vld = 1'b1;
        code     = c;
        @(negedge clk);
        code_vld = 1'b0;
        code     = '0;
    endtask

    task automatic pulse_wr;
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic send_key;
        send_code(8'hA5); send_code(8'h5A); send_code(8'hC3); send_code(8'h3C);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
    endtask

    // Counts negedge samples with pump_en high; optionally injects two codes
    task automatic run_pulse(input int inject_at, output int hi);
        hi = 0;
        for (int i = 0; i < 1200; i++) begin
            if (pump_en) hi++;
            code_vld = (i == inject_at) || (i == inject_at + 1);
            code     = (i == inject_at) ? 8'hA5 : 8'h5A;
            @(negedge clk);
        end
        code_vld = 1'b0;
        code     = '0;
    endtask

    function automatic logic [15:0] ref_sig(input logic [15:0] base);
        logic [15:0] r = 16'hFFFF;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] w = base ^ 16'(k * 16'h1357);
            for (int b = 0; b < 16; b++) begin
                logic fb = r[15] ^ w[15 - b];
                r = (r << 1) ^ ({16{fb}} & 16'h1021);
            end
        end
        return r;
    endfunction

    task automatic t_reset;
        check("R1", "pump_en", 32'(pump_en), 0);
        check("R1", "key_ok", 32'(key_ok), 0);
        check("R1", "perm_locked", 32'(perm_locked), 0);
        check("R1", "sig_done", 32'(sig_done), 0);
        check("R1", "sig_err", 32'(sig_err), 0);
    endtask

    task automatic t_unlock;
        int hi;
        send_key;
        check("R2", "key_ok after key", 32'(key_ok), 1);
        check("R2", "pump before request", 32'(pump_en), 0);
        pulse_wr;
        check("R2", "pump after request", 32'(pump_en), 1);
        run_pulse(-10, hi);
        check("R5", "pulse length", 32'(hi), 1024);
        check("R5", "key_ok after pulse", 32'(key_ok), 0);
        pulse_wr;
        check("R5", "relocked after pulse", 32'(pump_en), 0);
    endtask

    task automatic t_wrong;
        send_code(8'hA5); send_code(8'h5A); send_code(8'h00);
        send_code(8'hC3); send_code(8'h3C);
        check("R3", "wrong third code", 32'(key_ok), 0);
        send_code(8'hA5); send_code(8'hA5); send_code(8'hC3); send_code(8'h3C);
        check("R3", "repeated first code", 32'(key_ok), 0);
        send_key;
        check("R3", "fresh key after error", 32'(key_ok), 1);
        send_code(8'hA5);
        check("R3", "code while armed", 32'(key_ok), 0);
        pulse_wr;
        check("R3", "no pump after disarm", 32'(pump_en), 0);
    endtask

    task automatic t_wr_noarm;
        pulse_wr;
        check("R6", "request in idle", 32'(pump_en), 0);
        send_code(8'hA5); send_code(8'h5A);
        pulse_wr;
        check("R6", "request mid key", 32'(pump_en), 0);
        check("R6", "not armed mid key", 32'(key_ok), 0);
        do_reset;
    endtask

    task automatic t_window;
        int hi;
        send_code(8'hA5); idle(255);
        send_code(8'h5A); idle(255);
        send_code(8'hC3); idle(255);
        send_code(8'h3C);
        check("R4", "gaps of 256 accepted", 32'(key_ok), 1);
        idle(255);
        check("R4", "armed at edge 255", 32'(key_ok), 1);
        idle(1);
        check("R4", "armed times out at 256", 32'(key_ok), 0);
        send_code(8'hA5); idle(256);
        send_code(8'h5A); send_code(8'hC3); send_code(8'h3C);
        check("R4", "gap of 257 voids", 32'(key_ok), 0);
        send_key; idle(255);
        pulse_wr;
        check("R4", "request at gap 256", 32'(pump_en), 1);
        run_pulse(-10, hi);
        check("R5", "pulse length after late request", 32'(hi), 1024);
        send_key; idle(256);
        pulse_wr;
        check("R4", "request at gap 257", 32'(pump_en), 0);
    endtask

    task automatic t_pulse_codes;
        int hi;
        send_key;
        pulse_wr;
        run_pulse(50, hi);
        check("R7", "pulse with codes inside", 32'(hi), 1024);
        check("R7", "idle after pulse", 32'(key_ok), 0);
    endtask

    task automatic t_sig(input logic [15:0] base, input bit corrupt);
        logic [15:0] exp = ref_sig(base);
        sig_ref   = corrupt ? (exp ^ 16'h0100) : exp;
        sig_start = 1'b1;
        @(negedge clk);
        sig_start = 1'b0;
        check("R10", "start clears done", 32'(sig_done), 0);
        check("R10", "start clears err", 32'(sig_err), 0);
        for (int k = 0; k < 8; k++) begin
            if (k == 7) check("R9", "not done before last word", 32'(sig_done), 0);
            word_vld = 1'b1;
            word     = base ^ 16'(k * 16'h1357);
            @(negedge clk);
        end
        word_vld = 1'b0;
        check("R9", "done after 8 words", 32'(sig_done), 1);
        check("R9", "signature compare", 32'(sig_err), 32'(corrupt));
        word_vld = 1'b1;
        word     = 16'hDEAD;
        idle(3);
        word_vld = 1'b0;
        check("R10", "extra words keep done", 32'(sig_done), 1);
        check("R10", "extra words keep err", 32'(sig_err), 32'(corrupt));
    endtask

    task automatic t_lock;
        send_key;
        pulse_wr;
        idle(10);
        check("R8", "pump running before lock", 32'(pump_en), 1);
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        check("R8", "pump cut by lock", 32'(pump_en), 0);
        check("R8", "lock latched", 32'(perm_locked), 1);
        send_key;
        check("R8", "key refused", 32'(key_ok), 0);
        pulse_wr;
        check("R8", "request refused", 32'(pump_en), 0);
        idle(5);
        check("R8", "lock sticky", 32'(perm_locked), 1);
        do_reset;
        check("R1", "reset clears lock", 32'(perm_locked), 0);
    endtask

    initial begin
        idle(2);
        rst = 1'b0;
        idle(1);
        t_reset;
        t_unlock;
        t_wrong;
        t_wr_noarm;
        t_window;
        t_pulse_codes;
        t_sig(16'h4C2A, 1'b0);
        t_sig(16'h9001, 1'b1);
        t_sig(16'h0000, 1'b0);
        t_lock;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule